// File: doc/BRIEF.md
# Partial Word Store Lane Generator

This block turns a "store bytes" request into exactly one aligned word write toward a big-endian memory port. A request carries a byte address, a data word and a mode bit. In begin mode the block writes the low-order bytes of the data word, from the addressed byte up to the end of its word. In end mode it writes the high-order bytes of the data word into the bytes of the word that come before the addressed byte. When end mode is given a word-aligned address, no byte is written. The block then issues a probe beat, which lets the memory side check write permission without storing anything.

Each beat carries a word-aligned address, a byte-enable mask, lane-aligned write data and a probe flag. A three-byte store always goes out as one masked beat and is never split into a byte write and a halfword write. This keeps the store atomic as seen from memory. Both the request side and the memory side use valid/ready handshakes. Only one beat is outstanding at a time.

Top module: `pws_lane_gen`

## Requirements
- R1: After reset `mem_valid` is 0 and `req_ready` is 1.
- R2: Memory is big-endian. Byte b of a word (b = 0..3) sits on data lane i = 3-b, which is bits 8i+7:8i of `mem_wdata`, and `mem_be[i]` enables that lane. With offset o = `req_addr[1:0]`, begin mode (`req_end`=0) enables bytes o..3. The mask is therefore 4'hF >> o.
- R3: End mode (`req_end`=1) with offset o in 1..3 enables bytes 0..o-1. The mask is therefore ~(4'hF >> o) & 4'hF.
- R4: End mode with offset 0 issues one beat with `mem_probe`=1, `mem_be`=0 and `mem_wdata`=0.
- R5: Each enabled lane of `mem_wdata` carries the same bits of `req_data`. Each disabled lane is driven to zero.
- R6: `mem_addr` equals `req_addr` with its two low bits cleared.
- R7: A three-byte store (begin mode with offset 1, or end mode with offset 3) is issued as a single beat with exactly three enables.
- R8: Each accepted request produces exactly one beat. `req_ready` is 0 while a beat is outstanding, and a request presented during that time is not taken.
- R9: While `mem_valid`=1 and `mem_ready`=0, every beat output holds its value.
- R10: `mem_probe` is 0 for every beat except the one described in R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken this cycle when valid |
| req_addr | input | ADDR_W | Byte address |
| req_data | input | DATA_W | Store data word |
| req_end | input | 1 | 0 selects begin mode, 1 selects end mode |
| mem_valid | output | 1 | Beat present |
| mem_ready | input | 1 | Memory takes the beat |
| mem_addr | output | ADDR_W | Word-aligned address |
| mem_be | output | DATA_W/8 | Lane enables |
| mem_wdata | output | DATA_W | Lane-aligned data, disabled lanes zero |
| mem_probe | output | 1 | Permission probe, no bytes written |

## Verification
The bench sweeps both modes across all four offsets with several data patterns. A swapped lane order would shift enables to the wrong end of the word, and a decoder with an off-by-one would write a byte too many or drop the edge byte. Aligned end-mode requests are checked for the probe beat with nothing enabled and zero data, since a design that lost this case would either emit no beat or write a full word. Memory stalls and requests raised during a stall catch two faults: a beat that changes before it is taken, and a second request that is taken early and overwrites the first beat.

// File: rtl/pws_pkg.sv
package pws_pkg;

  typedef enum logic {
    MODE_BEGIN = 1'b0,
    MODE_END   = 1'b1
  } pws_mode_e;

  // Returns whether big-endian byte number byte_no is written
  // for a given mode and address offset within the word.
  function automatic logic byte_hit(input pws_mode_e mode,
                                    input int unsigned ofs,
                                    input int unsigned byte_no);
    if (mode == MODE_BEGIN) return (byte_no >= ofs);
    else                    return (byte_no < ofs);
  endfunction

endpackage

// File: rtl/pws_lane_decode.sv
module pws_lane_decode
  import pws_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int NB    = DATA_W / 8,
  localparam int OFS_W = $clog2(NB)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic              end_mode,
  output logic [ADDR_W-1:0] word_addr,
  output logic [NB-1:0]     be,
  output logic [DATA_W-1:0] wdata,
  output logic              probe
);
  logic [OFS_W-1:0] ofs;
  pws_mode_e        mode;

  assign ofs  = addr[OFS_W-1:0];
  assign mode = pws_mode_e'(end_mode);

  assign word_addr = {addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
  assign probe     = (mode == MODE_END) && (ofs == '0);

  // Lane i carries big-endian byte NB-1-i.
  for (genvar i = 0; i < NB; i++) begin : g_lane
    assign be[i] = byte_hit(mode, int'(ofs), NB - 1 - i);
    assign wdata[8*i +: 8] = be[i] ? data[8*i +: 8] : 8'h00;
  end

endmodule

// File: rtl/pws_beat_hold.sv
module pws_beat_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_pay,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_pay
);
  logic         full_q;
  logic [W-1:0] pay_q;
  logic         take_in;
  logic         give_out;

  assign in_ready = !full_q;
  assign take_in  = in_valid && in_ready;
  assign give_out = full_q && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      pay_q  <= '0;
    end else begin
      if (take_in) begin
        full_q <= 1'b1;
        pay_q  <= in_pay;
      end else if (give_out) begin
        full_q <= 1'b0;
      end
    end
  end

  assign out_valid = full_q;
  assign out_pay   = pay_q;

  // R9: the held beat does not change while the sink stalls
  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !out_ready) |=> (full_q && $stable(pay_q)));

  // R8: an accepted item is always presented next cycle
  a_r8_take_gives_beat: assert property (@(posedge clk) disable iff (!rst_n)
    take_in |=> full_q);

endmodule

// File: rtl/pws_lane_gen.sv
module pws_lane_gen
  import pws_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int NB    = DATA_W / 8,
  localparam int PAY_W = ADDR_W + NB + DATA_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic              req_end,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [NB-1:0]     mem_be,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_probe
);
  logic [ADDR_W-1:0] dec_addr;
  logic [NB-1:0]     dec_be;
  logic [DATA_W-1:0] dec_wdata;
  logic              dec_probe;
  logic [PAY_W-1:0]  hold_out;
  logic              req_fire;

  pws_lane_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .addr      (req_addr),
    .data      (req_data),
    .end_mode  (req_end),
    .word_addr (dec_addr),
    .be        (dec_be),
    .wdata     (dec_wdata),
    .probe     (dec_probe)
  );

  pws_beat_hold #(.W(PAY_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_pay    ({dec_addr, dec_be, dec_wdata, dec_probe}),
    .out_valid (mem_valid),
    .out_ready (mem_ready),
    .out_pay   (hold_out)
  );

  assign {mem_addr, mem_be, mem_wdata, mem_probe} = hold_out;
  assign req_fire = req_valid && req_ready;

  // R4 / R10: a probe beat enables no lane and a non-probe beat enables some
  a_r4_probe_no_bytes: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_probe) |-> (mem_be == '0 && mem_wdata == '0));
  a_r10_write_has_bytes: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_probe) |-> (mem_be != '0));

  // R2 / R3: enables always touch one end of the word
  a_r2_r3_edge_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_probe) |-> (mem_be[0] || mem_be[NB-1]));

  // R6: the memory address is always word aligned
  a_r6_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_addr[$clog2(NB)-1:0] == '0));

  // R8: no request is taken while a beat is outstanding
  a_r8_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> !$past(req_fire));

  // R7: a three-byte store from the decoder is one beat with three lanes
  a_r7_three_in_one: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && $countones(dec_be) == 3) |=> ($countones(mem_be) == 3));

  // R5: disabled lanes carry zero
  for (genvar i = 0; i < NB; i++) begin : g_chk
    a_r5_lane_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_be[i]) |-> (mem_wdata[8*i +: 8] == 8'h00));
  end

endmodule

// File: tb/sim_pws_lane_gen.sv
`timescale 1ns/1ps
module sim_pws_lane_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [31:0] req_data = '0;
  logic        req_end = 1'b0;
  logic        mem_valid;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic        mem_probe;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  pws_lane_gen u0 (.*);

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      total++; bad++;
      $display("FAIL watchdog expired: cycles=%0d expected below 100000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic mode, input logic [31:0] addr,
                      input logic [31:0] data, input int stall);
    logic [3:0]  ebe;
    logic [31:0] edata;
    logic        eprb;
    int          o;
    o = int'(addr[1:0]);
    if (!mode) ebe = 4'hF >> o;
    else       ebe = ~(4'hF >> o) & 4'hF;
    eprb = mode && (o == 0);
    edata = data & {{8{ebe[3]}}, {8{ebe[2]}}, {8{ebe[1]}}, {8{ebe[0]}}};
    chk("R8 ready when idle", 64'(req_ready), 64'd1);
    req_valid = 1'b1; req_end = mode; req_addr = addr; req_data = data;
    @(posedge clk); #1;
    req_valid = 1'b0;
    chk("R8 beat issued", 64'(mem_valid), 64'd1);
    chk("R8 not ready while busy", 64'(req_ready), 64'd0);
    if (mode) chk(eprb ? "R4 probe be" : "R3 end be", 64'(mem_be), 64'(ebe));
    else      chk("R2 begin be", 64'(mem_be), 64'(ebe));
    chk("R5 wdata lanes", 64'(mem_wdata), 64'(edata));
    chk("R6 word addr", 64'(mem_addr), 64'({addr[31:2], 2'b00}));
    if (eprb) chk("R4 probe flag", 64'(mem_probe), 64'd1);
    else      chk("R10 no probe", 64'(mem_probe), 64'd0);
    if ((!mode && o == 1) || (mode && o == 3))
      chk("R7 three lanes one beat", 64'($countones(mem_be)), 64'd3);
    for (int s = 0; s < stall; s++) begin
      req_valid = 1'b1; req_addr = ~addr; req_data = ~data; req_end = ~mode;
      @(posedge clk); #1;
      chk("R9 held be", 64'(mem_be), 64'(ebe));
      chk("R9 held data", 64'(mem_wdata), 64'(edata));
      chk("R9 held valid", 64'(mem_valid), 64'd1);
    end
    mem_ready = 1'b1;
    @(posedge clk); #1;
    mem_ready = 1'b0;
    req_valid = 1'b0;
    chk("R8 single beat, busy request ignored", 64'(mem_valid), 64'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset valid", 64'(mem_valid), 64'd0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 reset ready", 64'(req_ready), 64'd1);
    for (int m = 0; m < 2; m++)
      for (int o = 0; o < 4; o++)
        for (int p = 0; p < 4; p++) begin
          logic [31:0] a;
          logic [31:0] d;
          a = 32'hA000_0000 + 32'(p) * 32'h0001_0040 + 32'(o) * 32'h100 + 32'(o);
          d = 32'h1122_3344 ^ (32'(p) * 32'h5A5A_A5A5) ^ 32'(m * 32'hFF00_00FF);
          send(m[0], a, d, p % 3);
        end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule